// File: doc/BRIEF.md
# Programmable interrupt line router

This block collects 128 level-style interrupt request lines and steers each of them onto one of 24 output lines that feed a downstream interrupt controller. Every input owns a 32-bit routing word in a memory-mapped window: an enable flag plus the number of the output it should drive. An output is the OR of all enabled inputs that select it, so many sources can share one output line while others get a line of their own.

Because a shared output does not say which source raised it, the block also exposes a 128-bit read-only bank of the synchronised input levels. Software reads that bank and masks it against the inputs it has enabled on that output. Inputs are assumed asynchronous and pass through two flip-flops before they reach either the routing logic or the status bank. Register access is a plain 32-bit bus with a write strobe and a combinational read port.

Top module: `irq_router`

## Requirements
- R1: After reset every routing word reads as zero, so every input is disabled, and all 24 outputs are low.
- R2: The routing word of input n sits at byte address 4*n. A write stores bit 31 as the enable flag and bits 4:0 as the output select; a read returns those two fields in the same positions with bits 30:5 reading as zero.
- R3: Output k is high while at least one enabled input whose select equals k is high; inputs that share an output are ORed together.
- R4: A change on an input shows up in the status bank after two rising clock edges and on the outputs after three rising clock edges.
- R5: Writing zero to a routing word removes that input from every output.
- R6: An enabled input whose select is 24 or more drives no output.
- R7: The status bank is four read-only words at byte addresses 0x420, 0x424, 0x428 and 0x42C; input n appears at bit n mod 32 of the word at 0x420 + 4*(n/32), whether or not the input is enabled.
- R8: Writes to the status bank or to any address outside the routing words change no state, and reads from addresses that are neither routing words nor status words return zero. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 128 | Asynchronous interrupt request lines, active high |
| irq_out | output | 24 | Registered routed interrupt lines, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The hardest situation to reach from the ports is an output shared by several sources where one source drops while another is still high, and where a disabled or out-of-range source sits on the same input pattern. The stimulus routes two inputs to the same output, toggles them one at a time, and adds an input routed to select 24 and 31 and another that is merely disabled, then compares the outputs against a bench model after the three-edge latency. The status bank is read with a mix of enabled and disabled inputs high so that its independence from the enables is visible at the read port.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_IN      = 128,
  parameter int N_OUT     = 24,
  parameter int SEL_W     = 5,
  parameter int AW        = 12,
  parameter int STAT_BASE = 'h420
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  irq_in,
  output logic [N_OUT-1:0] irq_out,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  localparam int IW      = $clog2(N_IN);
  localparam int N_WORDS = N_IN / 32;
  localparam logic [AW-3:0] ROUTE_WORDS = (AW-2)'(N_IN);
  localparam logic [AW-3:0] STAT_W0     = (AW-2)'(STAT_BASE / 4);

  logic [N_IN-1:0]  sync1, sync2, en;
  logic [SEL_W-1:0] sel [N_IN];
  logic [N_OUT-1:0] route_or;

  wire [AW-3:0] widx     = addr[AW-1:2];
  wire [IW-1:0] ridx     = widx[IW-1:0];
  wire          is_route = widx < ROUTE_WORDS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      for (int i = 0; i < N_IN; i++) sel[i] <= '0;
    end else if (wr_en && is_route) begin
      en[ridx]  <= wdata[31];
      sel[ridx] <= wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    route_or = '0;
    for (int k = 0; k < N_OUT; k++)
      for (int n = 0; n < N_IN; n++)
        route_or[k] = route_or[k] | (en[n] & sync2[n] & (sel[n] == SEL_W'(k)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= route_or;
  end

  always_comb begin
    rdata = '0;
    if (is_route) begin
      rdata[31]        = en[ridx];
      rdata[SEL_W-1:0] = sel[ridx];
    end
    for (int w = 0; w < N_WORDS; w++)
      if (widx == STAT_W0 + (AW-2)'(w)) rdata = sync2[w*32 +: 32];
  end
endmodule

module irq_router_chk #(
  parameter int N_IN      = 128,
  parameter int N_OUT     = 24,
  parameter int AW        = 12,
  parameter int STAT_BASE = 'h420
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [N_OUT-1:0] irq_out,
  input logic [N_IN-1:0]  sync2,
  input logic [N_IN-1:0]  en
);
  localparam int IW = $clog2(N_IN);
  localparam logic [AW-1:0] ROUTE_END = AW'(N_IN * 4);
  localparam logic [AW-1:0] STAT_A    = AW'(STAT_BASE);

  a_r3_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == '0) |=> (irq_out == '0));

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr < ROUTE_END) |=> (en[$past(addr[IW+1:2])] == $past(wdata[31])));

  a_r8_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ROUTE_END && addr < STAT_A) |-> (rdata == '0));

  a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= STAT_A) |=> $stable(en));

  a_r7_status_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[AW-1:2] == STAT_A[AW-1:2]) |-> (rdata == sync2[31:0]));
endmodule

bind irq_router irq_router_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .AW(AW), .STAT_BASE(STAT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_out(irq_out), .sync2(sync2), .en(en)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [127:0] irq_in = '0;
  logic [23:0]  irq_out;
  logic         wr_en = 0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  bit       m_en  [128];
  bit [4:0] m_sel [128];

  always #2 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial begin : monitor
    forever begin
      item_t it;
      wait (q.size() != 0);
      #1;
      it = q[0];
      total++;
      if (it.is_out) begin
        if ({8'b0, irq_out} !== it.exp) begin
          bad++;
          $display("FAIL %s: irq_out actual=%h expected=%h", it.tag, irq_out, it.exp[23:0]);
        end
      end else if (rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: rdata @%h actual=%h expected=%h", it.tag, addr, rdata, it.exp);
      end
      void'(q.pop_front());
    end
  end

  function automatic logic [23:0] model_out();
    logic [23:0] r = '0;
    for (int k = 0; k < 24; k++)
      for (int n = 0; n < 128; n++)
        if (m_en[n] && m_sel[n] == 5'(k) && irq_in[n]) r[k] = 1'b1;
    return r;
  endfunction

  task automatic push(input bit is_out, input logic [31:0] e, input string tag);
    item_t it;
    it.is_out = is_out; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_out(input logic [23:0] e, input string tag);
    @(negedge clk);
    push(1, {8'b0, e}, tag);
  endtask

  task automatic chk_rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a[11:0];
    push(0, e, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a[11:0]; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic route(input int n, input logic [31:0] d);
    wr(n * 4, d);
    m_en[n] = d[31];
    m_sel[n] = d[4:0];
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic [127:0] pat;
    for (int n = 0; n < 128; n++) begin m_en[n] = 0; m_sel[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk_out(24'h0, "R1 outputs low after reset");
    chk_rd(5 * 4, 32'h0, "R1 routing word 5 zero");
    chk_rd(127 * 4, 32'h0, "R1 routing word 127 zero");

    route(3, 32'h8000_0007);
    chk_rd(3 * 4, 32'h8000_0007, "R2 readback word 3");
    route(10, 32'hFFFF_FFE2);
    chk_rd(10 * 4, 32'h8000_0002, "R2 bits 30:5 read zero");
    chk_rd(10 * 4 + 3, 32'h8000_0002, "R8 low address bits ignored");

    // R4 latency: drive at a falling edge, count rising edges
    @(negedge clk);
    irq_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    addr = 12'h420;
    push(1, 32'h0, "R4 output not yet changed after two edges");
    push(0, 32'h0000_0008, "R4 status visible after two edges");
    @(posedge clk);
    @(negedge clk);
    push(1, 32'h0000_0080, "R4 R3 output 7 after three edges");

    route(20, 32'h8000_0007);
    irq_in[20] = 1'b1; irq_in[3] = 1'b0;
    settle();
    chk_out(model_out(), "R3 shared output held by second source");
    irq_in[3] = 1'b1;
    settle();
    chk_out(model_out(), "R3 both sources on shared output");
    irq_in[3] = 1'b0; irq_in[20] = 1'b0;
    settle();
    chk_out(24'h0, "R3 shared output drops when all sources low");

    route(64, 32'h8000_0017);
    route(127, 32'h8000_0000);
    irq_in[64] = 1'b1; irq_in[127] = 1'b1; irq_in[10] = 1'b1;
    settle();
    chk_out(24'h80_0005, "R3 distinct outputs 23, 2 and 0");

    route(50, 32'h8000_0018);
    route(51, 32'h8000_001F);
    irq_in[50] = 1'b1; irq_in[51] = 1'b1;
    settle();
    chk_out(24'h80_0005, "R6 select 24 and 31 drive nothing");

    route(64, 32'h0);
    settle();
    chk_out(24'h00_0005, "R5 zero write removes input 64");
    chk_rd(64 * 4, 32'h0, "R5 word 64 reads zero");

    pat = '0;
    pat[0] = 1; pat[33] = 1; pat[64] = 1; pat[95] = 1; pat[96] = 1; pat[127] = 1; pat[50] = 1;
    irq_in = pat;
    settle();
    chk_rd(12'h420, pat[31:0],   "R7 status word 0");
    chk_rd(12'h424, pat[63:32],  "R7 status word 1 with disabled inputs");
    chk_rd(12'h428, pat[95:64],  "R7 status word 2");
    chk_rd(12'h42C, pat[127:96], "R7 status word 3");
    chk_out(model_out(), "R3 output for status pattern");

    wr(12'h420, 32'hFFFF_FFFF);
    wr(12'h300, 32'h8000_0001);
    wr(12'h42C, 32'hFFFF_FFFF);
    chk_rd(12'h420, pat[31:0], "R8 status write ignored");
    chk_rd(12'h300, 32'h0, "R8 unmapped read zero");
    chk_rd(12'h430, 32'h0, "R8 read past window zero");
    chk_rd(3 * 4, 32'h8000_0007, "R8 routing word 3 unchanged");
    chk_rd(0, 32'h0, "R8 routing word 0 unchanged");
    settle();
    chk_out(model_out(), "R8 outputs unchanged by ignored writes");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule